// File: doc/BRIEF.md
# Memory Window Address Decoder

A display DMA master issues 32-bit memory addresses. This block decides which memory target each address belongs to. Six programmable windows each describe a naturally aligned region whose size is a multiple of 64 KB. A window holds an enable, a size, an 8-bit attribute, a 4-bit target identifier, a base and a remap value. The windows are programmed through a simple write port. Each window occupies a 16-byte slot in that register space.

For every valid request, the block compares the upper half of the address against all enabled windows. When more than one window matches, the lowest-numbered one is chosen. One cycle later the block reports the result: a hit or miss flag, the winning window number, its target identifier and attribute, and a translated address. The translated address takes its region bits from the remap value and keeps the request's offset inside the window.

Top module: `mwd_decoder`

## Requirements
- R1: After reset every control, base and remap field is zero, so every window is disabled. Any request then returns miss=1, hit=0, and zero window, target, attribute and address.
- R2: Writes decode as follows. The window index is wr_addr_i[7:4]. The word select is wr_addr_i[3:2]: 0 selects control, 1 selects base, 3 selects remap. Word select 2, and window indices 6 to 15, change nothing. wr_addr_i[1:0] is ignored.
- R3: Control bit 0 is the enable. A window whose enable is 0 never produces a hit, whatever its other fields hold.
- R4: Control bits 31:16 hold size-minus-one in 64 KB units, and only bits 31:16 of the base are used. A request hits window w when (addr[31:16] & ~size_m1) == (base[31:16] & ~size_m1).
- R5: When several enabled windows match, the one with the lowest index is reported.
- R6: On a hit, rsp_win_o is the window index, rsp_target_o is control bits 7:4 and rsp_attr_o is control bits 15:8 of that window.
- R7: On a hit, rsp_addr_o[15:0] equals the request's bits 15:0. Each bit of rsp_addr_o[31:16] comes from remap[31:16] where size_m1 is 0, and from the request address where size_m1 is 1.
- R8: A valid request that matches no window gives miss=1 and hit=0, with window, target, attribute and address all zero.
- R9: rsp_valid_o follows req_valid_i by exactly one cycle. When rsp_valid_o is 0, both hit and miss are 0.
- R10: A register write in the same cycle as a request does not affect that request. It applies from the next request on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register byte address (window slot and word select) |
| wr_data_i | input | 32 | Register write data |
| req_valid_i | input | 1 | Request address valid |
| req_addr_i | input | 32 | Request address from the DMA master |
| rsp_valid_o | output | 1 | Decode result valid (one cycle after the request) |
| rsp_hit_o | output | 1 | Request matched an enabled window |
| rsp_miss_o | output | 1 | Request matched no window |
| rsp_win_o | output | 3 | Index of the winning window |
| rsp_target_o | output | 4 | Target identifier of the winning window |
| rsp_attr_o | output | 8 | Attribute byte of the winning window |
| rsp_addr_o | output | 32 | Translated address |

## Verification
Some situations only arise from particular register contents. The priority rule needs two enabled windows whose regions overlap. Remap merging needs a window larger than 64 KB, so that masked and unmasked bits mix. The bench programs these layouts on purpose. It then disables the lower window so that the higher one takes over. It also places a control write in the same cycle as a request, which covers the write-ordering rule. A long pseudo-random phase follows. It mixes writes to every slot, including the ignored ones, with requests drawn mostly from the programmed regions and their edges. A cycle-accurate behavioural model checks every response.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
  localparam int ADDR_W    = 32;
  localparam int PAGE_BITS = 16;
  localparam int HI_W      = ADDR_W - PAGE_BITS;
  localparam int TGT_W     = 4;
  localparam int ATTR_W    = 8;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_BASE  = 2'd1,
    REG_RSVD  = 2'd2,
    REG_REMAP = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic              en;
    logic [TGT_W-1:0]  tgt;
    logic [ATTR_W-1:0] attr;
    logic [HI_W-1:0]   size_m1;
    logic [HI_W-1:0]   base;
    logic [HI_W-1:0]   remap;
  } win_cfg_t;
endpackage

// File: rtl/mwd_regfile.sv
module mwd_regfile
  import mwd_pkg::*;
#(
  parameter int NUM_WIN = 6,
  parameter int REG_AW  = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [REG_AW-1:0]        wr_addr_i,
  input  logic [ADDR_W-1:0]        wr_data_i,
  output win_cfg_t [NUM_WIN-1:0]   cfg_o
);
  localparam int IDX_W = REG_AW - 4;

  logic [IDX_W-1:0] wsel;
  reg_sel_e         rsel;
  win_cfg_t         cfg_q [NUM_WIN];
  logic             unused_bits;

  assign wsel = wr_addr_i[REG_AW-1:4];
  assign rsel = reg_sel_e'(wr_addr_i[3:2]);
  assign unused_bits = ^{wr_addr_i[1:0], wr_data_i[3:1]};

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[w] <= '0;
      end else if (wr_en_i && wsel == IDX_W'(w)) begin
        unique case (rsel)
          REG_CTRL: begin
            cfg_q[w].en      <= wr_data_i[0];
            cfg_q[w].tgt     <= wr_data_i[7:4];
            cfg_q[w].attr    <= wr_data_i[15:8];
            cfg_q[w].size_m1 <= wr_data_i[ADDR_W-1:PAGE_BITS];
          end
          REG_BASE:  cfg_q[w].base  <= wr_data_i[ADDR_W-1:PAGE_BITS];
          REG_REMAP: cfg_q[w].remap <= wr_data_i[ADDR_W-1:PAGE_BITS];
          default: ;
        endcase
      end
    end
    assign cfg_o[w] = cfg_q[w];
  end
endmodule

// File: rtl/mwd_match.sv
module mwd_match
  import mwd_pkg::*;
#(
  parameter int NUM_WIN = 6
) (
  input  win_cfg_t [NUM_WIN-1:0] cfg_i,
  input  logic [HI_W-1:0]        addr_hi_i,
  output logic [NUM_WIN-1:0]     hit_vec_o
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    logic [HI_W-1:0] keep;
    assign keep = ~cfg_i[w].size_m1;
    assign hit_vec_o[w] = cfg_i[w].en &&
                          ((addr_hi_i & keep) == (cfg_i[w].base & keep));
  end
endmodule

// File: rtl/mwd_prio.sv
module mwd_prio #(
  parameter int NUM_WIN = 6,
  localparam int IDX_W  = $clog2(NUM_WIN)
) (
  input  logic [NUM_WIN-1:0] vec_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o
);
  // lowest index wins: scan downward so lower indices overwrite
  always_comb begin
    idx_o = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign found_o = |vec_i;
endmodule

// File: rtl/mwd_decoder.sv
module mwd_decoder
  import mwd_pkg::*;
#(
  parameter int NUM_WIN = 6,
  parameter int REG_AW  = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [REG_AW-1:0]           wr_addr_i,
  input  logic [31:0]                 wr_data_i,
  input  logic                        req_valid_i,
  input  logic [31:0]                 req_addr_i,
  output logic                        rsp_valid_o,
  output logic                        rsp_hit_o,
  output logic                        rsp_miss_o,
  output logic [$clog2(NUM_WIN)-1:0]  rsp_win_o,
  output logic [3:0]                  rsp_target_o,
  output logic [7:0]                  rsp_attr_o,
  output logic [31:0]                 rsp_addr_o
);
  localparam int IDX_W = $clog2(NUM_WIN);

  win_cfg_t [NUM_WIN-1:0] cfg;
  logic [NUM_WIN-1:0]     hit_vec;
  logic                   found;
  logic [IDX_W-1:0]       idx;
  win_cfg_t               sel;
  logic [HI_W-1:0]        xlat_hi;

  mwd_regfile #(.NUM_WIN(NUM_WIN), .REG_AW(REG_AW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg)
  );

  mwd_match #(.NUM_WIN(NUM_WIN)) u_match (
    .cfg_i     (cfg),
    .addr_hi_i (req_addr_i[ADDR_W-1:PAGE_BITS]),
    .hit_vec_o (hit_vec)
  );

  mwd_prio #(.NUM_WIN(NUM_WIN)) u_prio (
    .vec_i   (hit_vec),
    .found_o (found),
    .idx_o   (idx)
  );

  assign sel     = cfg[idx];
  assign xlat_hi = (sel.remap & ~sel.size_m1) |
                   (req_addr_i[ADDR_W-1:PAGE_BITS] & sel.size_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_hit_o    <= 1'b0;
      rsp_miss_o   <= 1'b0;
      rsp_win_o    <= '0;
      rsp_target_o <= '0;
      rsp_attr_o   <= '0;
      rsp_addr_o   <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_hit_o   <= req_valid_i & found;
      rsp_miss_o  <= req_valid_i & ~found;
      if (req_valid_i && found) begin
        rsp_win_o    <= idx;
        rsp_target_o <= sel.tgt;
        rsp_attr_o   <= sel.attr;
        rsp_addr_o   <= {xlat_hi, req_addr_i[PAGE_BITS-1:0]};
      end else begin
        rsp_win_o    <= '0;
        rsp_target_o <= '0;
        rsp_attr_o   <= '0;
        rsp_addr_o   <= '0;
      end
    end
  end
endmodule

// File: rtl/mwd_decoder_chk.sv
module mwd_decoder_chk #(
  parameter int NUM_WIN = 6
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       wr_en_i,
  input logic                       req_valid_i,
  input logic [31:0]                req_addr_i,
  input logic                       rsp_valid_o,
  input logic                       rsp_hit_o,
  input logic                       rsp_miss_o,
  input logic [$clog2(NUM_WIN)-1:0] rsp_win_o,
  input logic [3:0]                 rsp_target_o,
  input logic [7:0]                 rsp_attr_o,
  input logic [31:0]                rsp_addr_o
);
  logic touched_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) touched_q <= 1'b0;
    else if (wr_en_i) touched_q <= 1'b1;
  end

  AST_NO_HIT_UNPROGRAMMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> touched_q); // R1
  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o == $past(req_valid_i)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (!rsp_hit_o && !rsp_miss_o)); // R9
  AST_HIT_MISS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_hit_o != rsp_miss_o)); // R8
  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_miss_o |-> (rsp_win_o == '0 && rsp_target_o == '0 &&
                    rsp_attr_o == '0 && rsp_addr_o == '0)); // R8
  AST_WIN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> (32'(rsp_win_o) < NUM_WIN)); // R2
  AST_OFFSET_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> (rsp_addr_o[15:0] == $past(req_addr_i[15:0]))); // R7
endmodule

bind mwd_decoder mwd_decoder_chk #(.NUM_WIN(NUM_WIN)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .req_valid_i  (req_valid_i),
  .req_addr_i   (req_addr_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_hit_o    (rsp_hit_o),
  .rsp_miss_o   (rsp_miss_o),
  .rsp_win_o    (rsp_win_o),
  .rsp_target_o (rsp_target_o),
  .rsp_attr_o   (rsp_attr_o),
  .rsp_addr_o   (rsp_addr_o)
);

// File: tb/sim_mwd_decoder.sv
`timescale 1ns/1ps
module sim_mwd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        req_v = 1'b0;
  logic [31:0] req_a = '0;
  logic        rsp_valid, rsp_hit, rsp_miss;
  logic [2:0]  rsp_win;
  logic [3:0]  rsp_tgt;
  logic [7:0]  rsp_attr;
  logic [31:0] rsp_addr;

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_tag  = "R1";
  bit    done     = 1'b0;

  always #5 clk = ~clk;

  mwd_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .req_valid_i(req_v), .req_addr_i(req_a),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_miss_o(rsp_miss),
    .rsp_win_o(rsp_win), .rsp_target_o(rsp_tgt), .rsp_attr_o(rsp_attr),
    .rsp_addr_o(rsp_addr)
  );

  // behavioural reference model
  logic [31:0] m_ctrl [6];
  logic [31:0] m_base [6];
  logic [31:0] m_remap[6];
  logic [49:0] exp_vec = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < 6; w++) begin
        m_ctrl[w] = 0; m_base[w] = 0; m_remap[w] = 0;
      end
      exp_vec = '0;
    end else begin
      logic        h;
      logic [2:0]  wi;
      logic [3:0]  tg;
      logic [7:0]  at;
      logic [31:0] ad;
      h = 0; wi = 0; tg = 0; at = 0; ad = 0;
      if (req_v) begin
        for (int w = 0; w < 6; w++) begin
          logic [15:0] sz;
          sz = m_ctrl[w][31:16];
          if (!h && m_ctrl[w][0] &&
              ((req_a[31:16] & ~sz) == (m_base[w][31:16] & ~sz))) begin
            h  = 1;
            wi = 3'(w);
            tg = m_ctrl[w][7:4];
            at = m_ctrl[w][15:8];
            ad = {(m_remap[w][31:16] & ~sz) | (req_a[31:16] & sz), req_a[15:0]};
          end
        end
      end
      exp_vec = {req_v, h, req_v & ~h, wi, tg, at, ad};
      if (wr_en && wr_addr[7:4] < 6) begin
        case (wr_addr[3:2])
          2'd0: m_ctrl[wr_addr[7:4]]  = wr_data;
          2'd1: m_base[wr_addr[7:4]]  = wr_data;
          2'd3: m_remap[wr_addr[7:4]] = wr_data;
          default: ;
        endcase
      end
    end
  end

  task automatic compare();
    logic [49:0] act;
    act = {rsp_valid, rsp_hit, rsp_miss, rsp_win, rsp_tgt, rsp_attr, rsp_addr};
    n_checks++;
    if (act !== exp_vec) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", cur_tag, act, exp_vec);
    end
  endtask

  task automatic step(input logic we, input logic [7:0] wa, input logic [31:0] wd,
                      input logic rv, input logic [31:0] ra);
    @(negedge clk);
    compare();
    wr_en = we; wr_addr = wa; wr_data = wd; req_v = rv; req_a = ra;
  endtask

  task automatic wr(input logic [7:0] wa, input logic [31:0] wd);
    step(1'b1, wa, wd, 1'b0, 32'h0);
  endtask

  task automatic rq(input logic [31:0] ra);
    step(1'b0, 8'h0, 32'h0, 1'b1, ra);
  endtask

  task automatic idle();
    step(1'b0, 8'h0, 32'h0, 1'b0, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    repeat (3) @(negedge clk);
    cur_tag = "R1";
    compare();  // outputs zero while in reset
    rst_n = 1'b1;
    rq(32'h0000_0000);
    rq(32'h1000_1234);
    idle();

    // window 0: 64 KB at 0x1000_0000, attr A5, target 3, remap 0x8000
    cur_tag = "R6";
    wr(8'h04, 32'h1000_0000);
    wr(8'h0C, 32'h8000_0000);
    wr(8'h00, 32'h0000_A531);
    rq(32'h1000_1234);
    cur_tag = "R4";
    rq(32'h1001_0000);
    rq(32'h0FFF_FFFF);
    wr(8'h04, 32'h1000_FFFF);  // low base bits ignored
    rq(32'h1000_FFFF);

    // window 2: 1 MB, merged remap
    cur_tag = "R7";
    wr(8'h24, 32'h2030_0000);
    wr(8'h2C, 32'h4000_0000);
    wr(8'h20, 32'h000F_5C71);
    rq(32'h203A_BCDE);
    rq(32'h2030_0000);
    cur_tag = "R8";
    rq(32'h2040_0000);

    // overlap: window 1 covers window 0 region
    cur_tag = "R5";
    wr(8'h14, 32'h1000_0000);
    wr(8'h1C, 32'hC000_0000);
    wr(8'h10, 32'h00FF_3351);
    rq(32'h1000_0010);
    rq(32'h10AB_0010);
    cur_tag = "R3";
    wr(8'h00, 32'h0000_A530);  // disable window 0
    rq(32'h1000_0010);
    wr(8'h10, 32'hFFFF_FFF0);  // window 1 disabled, huge size
    rq(32'h1000_0010);
    rq(32'h7777_7777);

    // ignored writes
    cur_tag = "R2";
    wr(8'h28, 32'hFFFF_FFFF);  // word select 2
    wr(8'h60, 32'h0000_0001);  // window 6
    wr(8'hF0, 32'h0000_0001);  // window 15
    rq(32'h0000_0000);
    rq(32'h203A_0001);
    wr(8'h54, 32'hABCD_0000);
    wr(8'h5F, 32'h1234_0000);  // low addr bits ignored, remap slot
    wr(8'h50, 32'h0000_77E1);
    rq(32'hABCD_4321);

    // same-cycle write and request
    cur_tag = "R10";
    step(1'b1, 8'h00, 32'h0000_A531, 1'b1, 32'h1000_0042);
    rq(32'h1000_0042);
    step(1'b1, 8'h00, 32'h0000_A530, 1'b1, 32'h1000_0042);
    rq(32'h1000_0042);

    // latency with gaps
    cur_tag = "R9";
    rq(32'hABCD_0001);
    idle();
    rq(32'h1000_0000);
    rq(32'h203F_FFFF);
    idle();
    idle();

    // mixed pseudo-random traffic
    cur_tag = "R4";
    seed = 32'h1ACE_B00C;
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r1, r2;
      seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5; r1 = seed;
      seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5; r2 = seed;
      if (r1[2:0] == 3'd0) begin
        logic [31:0] d;
        d = r2;
        if (r1[6:5] == 2'd0) d[31:16] = {12'h0, r2[19:16]};
        step(1'b1, r1[15:8], d, r1[3], {r2[31:28], 12'h000, r2[15:0]});
      end else begin
        logic [15:0] hi;
        case (r1[5:3])
          3'd0: hi = 16'h1000;
          3'd1: hi = 16'h1001;
          3'd2: hi = 16'h2035;
          3'd3: hi = 16'hABCD;
          3'd4: hi = {r2[31:28], 12'h000};
          3'd5: hi = r2[31:16];
          default: hi = {r1[31:28], r2[27:16]};
        endcase
        step(1'b0, 8'h0, 32'h0, r1[6] | r1[7], {hi, r2[15:0]});
      end
    end
    idle();
    idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule